// File: doc/BRIEF.md
# Auto-Increment Word Program Sequencer

This block is the control core of a serial flash slave for its two-byte sequential programming mode. A serial front end hands it the bytes of each chip-enable window; the block parses them, keeps its own write-enable latch, and issues timed word writes to the array. The first program command carries an opcode, a full start address and two data bytes. Every later command in the mode carries only the opcode and two data bytes, and the target moves up by one word (two bytes) each time.

While the mode is active, only three opcodes are legal: the continuation opcode, status read and write disable. Any other opcode byte is flagged on a reject pulse and has no effect. The mode ends on write disable, or by itself once the word just written was the last one below a protected region or at the top of the address space. The block never wraps around. On request it can report ready/busy as a level on the serial output pin while chip enable is asserted.

The byte input is a valid/ready stream. `rx_ready` is held at 1, so the block never applies back-pressure; a byte counts on any cycle with `rx_valid` high while `cs_act` is high. The array write port is also a valid/ready stream. The block holds a request with its address and data stable until the array raises `wr_ready`. The array's programming time then runs for `PROG_CYCLES` cycles.

Top module: `aai_word_seq`

## Requirements
- R1: After reset the mode bit, the write-enable latch, busy, the write request and the ready/busy output enable are all 0.
- R2: A chip-enable window holding only opcode 06h sets the write-enable latch when chip enable is released. One holding only 04h clears it.
- R3: Outside the mode, the command AD h, three address bytes (most significant first) and two data bytes takes effect at release if three things hold: the latch is 1, no write is in progress, and the start word is unprotected. It then sets the mode bit and issues one write to the address with bit 0 forced to 0. The first data byte is on `wr_data[7:0]` (even byte) and the second on `wr_data[15:8]` (odd byte).
- R4: A start command is ignored, with no write and the mode bit still 0, in three cases: the latch is 0, the start word is protected, or fewer than six bytes were sent.
- R5: In the mode, a continuation (ADh plus two data bytes) writes the word two bytes above the previous word.
- R6: A continuation released while busy is 1 is discarded. No write is issued and the next accepted continuation still goes to the next word.
- R7: In the mode, an opcode byte other than ADh, 05h or 04h raises `cmd_rej` while that byte is presented, and the command changes nothing. Outside the mode `cmd_rej` stays 0.
- R8: Opcode 04h alone in the mode clears both the mode bit and the write-enable latch.
- R9: When a write finishes and the next word is protected or lies past the top address, the mode bit and the write-enable latch are both cleared.
- R10: `wr_valid` stays high with stable `wr_addr` and `wr_data` until `wr_ready`. After acceptance, busy stays 1 for exactly `PROG_CYCLES` cycles.
- R11: After opcode 70h (sent outside the mode), `rdy_oe` is 1 while `cs_act` is 1 and the mode is active, with `rdy_lvl` 0 for busy and 1 for ready. After 80h, `rdy_oe` stays 0. `rdy_oe` is 0 whenever `cs_act` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_act | input | 1 | Chip enable asserted (1 = selected) |
| rx_valid | input | 1 | Received byte valid |
| rx_ready | output | 1 | Byte accepted (always 1) |
| rx_byte | input | 8 | Received byte |
| chk_addr | output | ADDR_W | Address given to the protection decode |
| chk_prot | input | 1 | 1 = `chk_addr` is protected |
| wr_valid | output | 1 | Word write request |
| wr_ready | input | 1 | Array accepts the request |
| wr_addr | output | ADDR_W | Even byte address of the word |
| wr_data | output | 16 | Even byte in [7:0], odd byte in [15:8] |
| aai_mode | output | 1 | Sequential word mode active |
| wel | output | 1 | Write-enable latch |
| busy | output | 1 | Write pending or in progress |
| rdy_oe | output | 1 | Drive ready/busy on the serial output |
| rdy_lvl | output | 1 | Ready/busy level (1 = ready) |
| cmd_rej | output | 1 | Illegal opcode in the mode |

## Verification
The assertions check on every cycle that a pending write holds its address and data, that the mode never stays on without the write-enable latch, that entering the mode always comes with a write request, and that leaving it always leaves the latch clear. Only the bench's scenarios can show the command-level outcomes. These are the ignored start commands, the discarded busy continuations, the word-by-word address advance, the exit below a protected region and at the top of the space, the reject pulse, and the exact busy duration.

// File: rtl/aai_pkg.sv
package aai_pkg;
  localparam logic [7:0] OP_SEQ    = 8'hAD;
  localparam logic [7:0] OP_STAT   = 8'h05;
  localparam logic [7:0] OP_WDIS   = 8'h04;
  localparam logic [7:0] OP_WEN    = 8'h06;
  localparam logic [7:0] OP_RB_ON  = 8'h70;
  localparam logic [7:0] OP_RB_OFF = 8'h80;

  typedef enum logic [1:0] {WT_IDLE, WT_REQ, WT_RUN} wt_state_e;

  typedef struct packed {
    logic [7:0] op;
    logic [7:0] d0;
    logic [7:0] d1;
  } cmd_hdr_t;
endpackage

// File: rtl/aai_cmd_rx.sv
module aai_cmd_rx
  import aai_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              rx_valid,
  input  logic [7:0]        rx_byte,
  input  logic              in_mode,
  output logic              op_stb,
  output logic              ev,
  output logic [CNT_W-1:0]  cnt,
  output cmd_hdr_t          hdr,
  output logic [ADDR_W-1:0] addr
);
  localparam int ABYTES = (ADDR_W + 7) / 8;
  localparam logic [CNT_W-1:0] LAST_A  = CNT_W'(ABYTES);
  localparam logic [CNT_W-1:0] DPOS_HI = CNT_W'(ABYTES + 1);
  localparam logic [CNT_W-1:0] DPOS_LO = CNT_W'(1);

  logic             cs_q;
  logic [CNT_W-1:0] dpos;

  assign dpos   = in_mode ? DPOS_LO : DPOS_HI;
  assign op_stb = cs_act && rx_valid && (cnt == '0);
  assign ev     = cs_q && !cs_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b0;
      cnt  <= '0;
      hdr  <= '0;
      addr <= '0;
    end else begin
      cs_q <= cs_act;
      if (!cs_act) begin
        cnt <= '0;
      end else if (rx_valid) begin
        if (cnt != '1) cnt <= cnt + 1'b1;
        if (cnt == '0) hdr.op <= rx_byte;
        else if (!in_mode && cnt <= LAST_A) addr <= {addr[ADDR_W-9:0], rx_byte};
        if (cnt == dpos) hdr.d0 <= rx_byte;
        if (cnt == dpos + 1'b1) hdr.d1 <= rx_byte;
      end
    end
  end
endmodule

// File: rtl/aai_wr_timer.sv
module aai_wr_timer
  import aai_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [DATA_W-1:0] s_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              done
);
  localparam int TW = $clog2(PROG_CYCLES + 1);
  localparam logic [TW-1:0] T_LOAD = TW'(PROG_CYCLES - 1);

  wt_state_e     st;
  logic [TW-1:0] tmr;

  assign wr_valid = (st == WT_REQ);
  assign busy     = (st != WT_IDLE);
  assign done     = (st == WT_RUN) && (tmr == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= WT_IDLE;
      tmr     <= '0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      unique case (st)
        WT_IDLE: if (start) begin
          st      <= WT_REQ;
          wr_addr <= s_addr;
          wr_data <= s_data;
        end
        WT_REQ: if (wr_ready) begin
          st  <= WT_RUN;
          tmr <= T_LOAD;
        end
        WT_RUN: if (tmr == '0) st <= WT_IDLE;
                else tmr <= tmr - 1'b1;
        default: st <= WT_IDLE;
      endcase
    end
  end

  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));
endmodule

// File: rtl/aai_word_seq.sv
module aai_word_seq
  import aai_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int PROG_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_byte,
  output logic [ADDR_W-1:0] chk_addr,
  input  logic              chk_prot,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [15:0]       wr_data,
  output logic              aai_mode,
  output logic              wel,
  output logic              busy,
  output logic              rdy_oe,
  output logic              rdy_lvl,
  output logic              cmd_rej
);
  localparam int ABYTES = (ADDR_W + 7) / 8;
  localparam int CNT_W  = $clog2(ABYTES + 4);
  localparam logic [CNT_W-1:0] START_LEN = CNT_W'(ABYTES + 3);
  localparam logic [CNT_W-1:0] CONT_LEN  = CNT_W'(3);
  localparam logic [CNT_W-1:0] ONE_LEN   = CNT_W'(1);

  logic              op_stb, ev, wr_done, rb_q, top_q;
  logic [CNT_W-1:0]  cnt;
  cmd_hdr_t          hdr;
  logic [ADDR_W-1:0] cap_addr, start_even, ptr, tgt_addr;
  logic [ADDR_W-2:0] hi_inc;
  logic              carry, go_first, go_next, legal_op;

  aai_cmd_rx #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .in_mode(aai_mode), .op_stb(op_stb), .ev(ev),
    .cnt(cnt), .hdr(hdr), .addr(cap_addr)
  );

  assign start_even = {cap_addr[ADDR_W-1:1], 1'b0};
  assign tgt_addr   = aai_mode ? ptr : start_even;
  assign chk_addr   = tgt_addr;
  assign {carry, hi_inc} = {1'b0, tgt_addr[ADDR_W-1:1]} + ADDR_W'(1);

  assign go_first = ev && !aai_mode && (hdr.op == OP_SEQ) && (cnt >= START_LEN)
                    && wel && !busy && !chk_prot;
  assign go_next  = ev && aai_mode && (hdr.op == OP_SEQ) && (cnt >= CONT_LEN) && !busy;

  aai_wr_timer #(.ADDR_W(ADDR_W), .DATA_W(16), .PROG_CYCLES(PROG_CYCLES)) u_wt (
    .clk(clk), .rst_n(rst_n), .start(go_first || go_next), .s_addr(tgt_addr),
    .s_data({hdr.d1, hdr.d0}), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .done(wr_done)
  );

  assign legal_op = (rx_byte == OP_SEQ) || (rx_byte == OP_STAT) || (rx_byte == OP_WDIS);
  assign cmd_rej  = op_stb && aai_mode && !legal_op;
  assign rx_ready = 1'b1;
  assign rdy_oe   = cs_act && rb_q && aai_mode;
  assign rdy_lvl  = !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aai_mode <= 1'b0;
      wel      <= 1'b0;
      rb_q     <= 1'b0;
      top_q    <= 1'b0;
      ptr      <= '0;
    end else begin
      if (wr_done && aai_mode && (top_q || chk_prot)) begin
        aai_mode <= 1'b0;
        wel      <= 1'b0;
      end
      if (go_first || go_next) begin
        ptr   <= {hi_inc, 1'b0};
        top_q <= carry;
      end
      if (go_first) aai_mode <= 1'b1;
      if (ev && cnt == ONE_LEN) begin
        if (aai_mode) begin
          if (hdr.op == OP_WDIS) begin
            aai_mode <= 1'b0;
            wel      <= 1'b0;
          end
        end else begin
          case (hdr.op)
            OP_WEN:    wel  <= 1'b1;
            OP_WDIS:   wel  <= 1'b0;
            OP_RB_ON:  rb_q <= 1'b1;
            OP_RB_OFF: rb_q <= 1'b0;
            default: ;
          endcase
        end
      end
    end
  end

  // R3
  mode_rise_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aai_mode) |-> wr_valid);
  // R8
  mode_exit_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aai_mode) |-> !wel);
  // R4
  mode_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    aai_mode |-> wel);
  // R7
  rej_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_rej && !busy) |=> !wr_valid);
endmodule

// File: tb/tb_aai_word_seq.sv
module tb_aai_word_seq;
  localparam int AW = 24;
  localparam int PC = 16;

  logic clk = 1'b0;
  logic rst_n, cs_act, rx_valid, wr_ready, chk_prot;
  logic [7:0] rx_byte;
  logic rx_ready, wr_valid, aai_mode, wel, busy, rdy_oe, rdy_lvl, cmd_rej;
  logic [AW-1:0] chk_addr, wr_addr;
  logic [15:0] wr_data;
  logic [24:0] prot_base;

  int tests = 0, fails = 0, wr_cnt = 0, rej_seen = 0, ready_mode = 0;
  logic [AW-1:0] last_addr;
  logic [15:0] last_data;
  logic [7:0] cbuf [8];

  always #10 clk = ~clk;

  assign chk_prot = ({1'b0, chk_addr} >= prot_base);

  aai_word_seq #(.ADDR_W(AW), .PROG_CYCLES(PC)) dut (
    .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_byte(rx_byte), .chk_addr(chk_addr),
    .chk_prot(chk_prot), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .aai_mode(aai_mode), .wel(wel),
    .busy(busy), .rdy_oe(rdy_oe), .rdy_lvl(rdy_lvl), .cmd_rej(cmd_rej)
  );

  always @(negedge clk) begin
    if (ready_mode == 1) wr_ready = 1'b0;
    else if (ready_mode == 2) wr_ready = 1'b1;
    else wr_ready = ($urandom % 4) != 0;
    if (rst_n && wr_valid && wr_ready) begin
      wr_cnt++;
      last_addr = wr_addr;
      last_data = wr_data;
    end
  end

  function automatic logic [AW-1:0] even_of(input logic [AW-1:0] a);
    return {a[AW-1:1], 1'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(negedge clk);
    #1;
  endtask

  task automatic send(input int n);
    rej_seen = 0;
    step();
    cs_act = 1'b1;
    for (int i = 0; i < n; i++) begin
      step();
      rx_valid = 1'b1;
      rx_byte  = cbuf[i];
      #1;
      if (cmd_rej) rej_seen++;
      if ($urandom % 3 == 0) begin
        step();
        rx_valid = 1'b0;
      end
    end
    step();
    rx_valid = 1'b0;
    cs_act   = 1'b0;
    step();
  endtask

  task automatic op1(input logic [7:0] op);
    cbuf[0] = op;
    send(1);
  endtask

  task automatic start_cmd(input logic [AW-1:0] a, input logic [7:0] d0, input logic [7:0] d1, input int n);
    cbuf[0] = 8'hAD; cbuf[1] = a[23:16]; cbuf[2] = a[15:8]; cbuf[3] = a[7:0];
    cbuf[4] = d0; cbuf[5] = d1;
    send(n);
  endtask

  task automatic cont_cmd(input logic [7:0] d0, input logic [7:0] d1);
    cbuf[0] = 8'hAD; cbuf[1] = d0; cbuf[2] = d1;
    send(3);
  endtask

  task automatic wait_idle;
    step();
    while (busy) step();
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [AW-1:0] a, exp_a;
    logic [7:0] d0, d1;
    int wc, n;
    void'($urandom(32'h5EED_0A1D));
    rst_n = 1'b0; cs_act = 1'b0; rx_valid = 1'b0; rx_byte = 8'h00;
    prot_base = 25'h1000000;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R1 mode", aai_mode, 0); chk("R1 wel", wel, 0); chk("R1 busy", busy, 0);
    chk("R1 wr_valid", wr_valid, 0); chk("R1 rdy_oe", rdy_oe, 0);
    chk("R1 rx_ready", rx_ready, 1);

    start_cmd(24'h001000, 8'h11, 8'h22, 6);
    chk("R4 no wel mode", aai_mode, 0); chk("R4 no wel write", wr_cnt, 0);
    op1(8'h06); chk("R2 wren", wel, 1);
    op1(8'h04); chk("R2 wrdi", wel, 0);
    op1(8'h06);
    start_cmd(24'h001000, 8'h11, 8'h22, 5);
    chk("R4 short mode", aai_mode, 0); chk("R4 short write", wr_cnt, 0);
    prot_base = 25'h100000;
    start_cmd(24'h100010, 8'h11, 8'h22, 6);
    chk("R4 prot mode", aai_mode, 0); chk("R4 prot write", wr_cnt, 0); chk("R4 prot wel", wel, 1);

    a = {5'b0, 19'($urandom)} | 24'h1;
    d0 = 8'($urandom); d1 = 8'($urandom);
    ready_mode = 1;
    start_cmd(a, d0, d1, 6);
    chk("R3 mode set", aai_mode, 1);
    cont_cmd(8'hEE, 8'hEE);
    ready_mode = 0;
    wait_idle();
    chk("R3 one write", wr_cnt, 1);
    chk("R3 even addr", last_addr, even_of(a));
    chk("R3 byte order", last_data, {d1, d0});
    chk("R6 busy discard", wr_cnt, 1);
    exp_a = even_of(a);
    for (int k = 0; k < 8; k++) begin
      d0 = 8'($urandom); d1 = 8'($urandom);
      cont_cmd(d0, d1);
      wait_idle();
      exp_a = exp_a + 24'd2;
      chk("R5 next addr", last_addr, exp_a);
      chk("R5 data", last_data, {d1, d0});
    end

    wc = wr_cnt;
    op1(8'h06); chk("R7 reject wren", rej_seen, 1);
    op1(8'h70); chk("R7 reject 70h", rej_seen, 1);
    chk("R7 no write", wr_cnt, wc); chk("R7 mode kept", aai_mode, 1);
    op1(8'h05); chk("R7 status legal", rej_seen, 0);
    cont_cmd(8'h5A, 8'hA5); wait_idle();
    chk("R7 seq after reject", last_addr, exp_a + 24'd2);
    op1(8'h04);
    chk("R8 mode clr", aai_mode, 0); chk("R8 wel clr", wel, 0);
    op1(8'h9F); chk("R7 outside no reject", rej_seen, 0);

    op1(8'h70); op1(8'h06);
    ready_mode = 1;
    start_cmd(24'h000200, 8'h01, 8'h02, 6);
    cs_act = 1'b1; step();
    chk("R11 oe busy", rdy_oe, 1); chk("R11 lvl busy", rdy_lvl, 0);
    ready_mode = 0;
    while (busy) step();
    chk("R11 lvl ready", rdy_lvl, 1);
    cs_act = 1'b0; step();
    chk("R11 oe cs off", rdy_oe, 0);
    op1(8'h04); op1(8'h80); op1(8'h06);
    start_cmd(24'h000300, 8'h03, 8'h04, 6);
    cs_act = 1'b1; step();
    chk("R11 oe disabled", rdy_oe, 0);
    cs_act = 1'b0;
    wait_idle();
    op1(8'h04);

    op1(8'h06);
    ready_mode = 1;
    wc = wr_cnt;
    start_cmd(24'h000400, 8'h77, 8'h88, 6);
    repeat (5) step();
    chk("R10 hold valid", wr_valid, 1); chk("R10 hold addr", wr_addr, 24'h000400);
    chk("R10 hold data", wr_data, 16'h8877);
    ready_mode = 2;
    while (wr_cnt == wc) step();
    n = 0;
    step();
    while (busy) begin n++; step(); end
    chk("R10 busy length", n, PC);
    ready_mode = 0;
    op1(8'h04);

    op1(8'h06);
    start_cmd(24'h0FFFFC, 8'h10, 8'h20, 6);
    wait_idle();
    chk("R9 mode before top", aai_mode, 1);
    cont_cmd(8'h30, 8'h40); wait_idle();
    chk("R9 last addr", last_addr, 24'h0FFFFE);
    chk("R9 prot exit mode", aai_mode, 0); chk("R9 prot exit wel", wel, 0);
    prot_base = 25'h1000000;
    op1(8'h06);
    start_cmd(24'hFFFFFF, 8'h50, 8'h60, 6);
    wait_idle();
    chk("R9 top addr", last_addr, 24'hFFFFFE);
    chk("R9 top exit mode", aai_mode, 0); chk("R9 top exit wel", wel, 0);
    finish_run();
  end
endmodule